// File: doc/BRIEF.md
# Way-Partitioned Two-Level Cache Controller

This controller manages one physical cache array of four subarrays with four ways each. It presents the array as a non-inclusive pair of levels, a fast first level and a backing second level. A 3-bit configuration value decides which ways of which subarrays form the first level. For each request the controller produces the enable mask for the first-level probe and the first-level hit latency in half-cycles. On a first-level miss it probes every other way. It then issues either a swap command, when the line sits in the backing portion, or a fill command, when the line is absent everywhere.

Tags live in a small register array indexed by set. The data array itself is outside the block; the swap, fill and spill outputs tell the data path which positions to move. A position is numbered `subarray*4 + way`. The configuration can be rewritten between requests, so the level split can follow program phases. Lines that were placed under an earlier configuration are still found and moved through the swap path.

Top module: `waypart_cache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0, `probe_mask` is 0 and the configuration is 0.
- R2: Configuration `cfg` is decoded as `wide = cfg[2]` and `n = cfg[1:0] + 1` first-level ways per subarray. Each response reports the first-level latency in half-cycles. For `wide = 0` and n = 1, 2, 3, 4 the values are 4, 5, 5, 6. For `wide = 1` they are 6, 7, 8, 9.
- R3: The request address is `{tag, sa[1:0], idx}`, with `idx` in the low `IDX_W` bits. The selected subarray is `sa` when `wide = 1`, or `{0, sa[0]}` otherwise. One cycle after acceptance, `probe_mask` has bit `sel*4 + w` set for each way `w < n` and no other bit set.
- R4: Two cycles after acceptance of a first-level miss, `probe_mask` is the bitwise complement of the first-probe mask, and no response is given yet.
- R5: On a first-level hit, `resp_valid` and `resp_hit` pulse two cycles after acceptance, and no swap, fill or spill is signalled.
- R6: If a first-level miss matches a tag in any other position, the response comes three cycles after acceptance with `resp_hit = 0`. It carries a swap of the first-level victim (`swap_l1_pos`) with the matching position (`swap_l2_pos`), and the tags of the two positions are exchanged.
- R7: If no position matches, the response comes three cycles after acceptance with a fill of the victim (`fill_l1_pos`). A valid displaced line is spilled (`evict_valid`, `evict_l2_pos`) to the lowest invalid position of the pure second level: positions with `w >= n`, plus subarrays 2 and 3 when `wide = 0`. If all of these are valid, it goes to the lowest such position. There is no spill when that region is empty.
- R8: The victim is the lowest invalid first-level way of the selected subarray. If there is none, it is way `rr mod n`, where `rr` is a 2-bit counter that starts at 0 and advances on every missed response.
- R9: A configuration write is taken only while the controller is idle. A write during a busy cycle is ignored, and the next request still reports the old latency.
- R10: Tags are compared together with both subarray-select bits. A line placed under one configuration and requested under another is found in the second probe and swapped in.
- R11: `req_ready` is 1 only when the controller is idle, and it is 0 in the cycles after acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_in | input | 3 | New configuration value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | TAG_W+2+IDX_W | Request address {tag, sa, idx} |
| probe_mask | output | 16 | Way enables of the current probe, bit subarray*4+way |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | First-level hit |
| resp_lat_half | output | 4 | First-level latency in half-cycles |
| swap_valid | output | 1 | Swap command |
| swap_l1_pos | output | 4 | First-level position of the swap |
| swap_l2_pos | output | 4 | Other position of the swap |
| fill_valid | output | 1 | Fill command |
| fill_l1_pos | output | 4 | Position receiving the new line |
| evict_valid | output | 1 | Displaced line written to second level |
| evict_l2_pos | output | 4 | Destination of the displaced line |

## Verification
The first-probe mask is due one cycle after the acceptance edge. A first-level hit responds at the second edge. A miss shows the complementary mask at the second edge and responds at the third. The bench drives each request on a falling edge and waits a fixed number of falling edges for each stage. It compares mask, handshake and response at exactly those points, and checks that nothing arrives early. Expected victims, spill targets and swap partners come from a tag model in the bench that follows the requirement rules. This model is swept over all eight configurations in turn, so lines left from earlier configurations exercise the cross-configuration swap path.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;
  localparam int SUBS  = 4;
  localparam int WAYS  = 4;
  localparam int POS   = SUBS * WAYS;
  localparam int POS_W = $clog2(POS);
  localparam int SUB_W = $clog2(SUBS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int CFG_W = 3;
  localparam int LAT_W = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_PROBE_L1, ST_PROBE_REST} phase_t;

  function automatic logic [2:0] cfg_ways(input logic [CFG_W-1:0] cfg);
    return {1'b0, cfg[1:0]} + 3'd1;
  endfunction

  function automatic logic [LAT_W-1:0] cfg_lat(input logic [CFG_W-1:0] cfg);
    logic [LAT_W-1:0] base;
    base = cfg[2] ? 4'd6 : 4'd4;
    if (cfg[2]) return base + {2'b00, cfg[1:0]};
    case (cfg[1:0])
      2'd0:    return base;
      2'd3:    return base + 4'd2;
      default: return base + 4'd1;
    endcase
  endfunction

  function automatic logic [POS-1:0] l1_mask_of(input logic [CFG_W-1:0] cfg,
                                                input logic [SUB_W-1:0] sub);
    logic [POS-1:0] m;
    m = '0;
    for (int w = 0; w < WAYS; w++)
      if (w <= int'(cfg[1:0])) m[int'(sub)*WAYS + w] = 1'b1;
    return m;
  endfunction

  function automatic logic [POS-1:0] l2_region_of(input logic [CFG_W-1:0] cfg);
    logic [POS-1:0] m;
    m = '0;
    for (int s = 0; s < SUBS; s++)
      for (int w = 0; w < WAYS; w++)
        if ((!cfg[2] && s >= 2) || w > int'(cfg[1:0])) m[s*WAYS + w] = 1'b1;
    return m;
  endfunction

  function automatic logic [POS_W-1:0] lowest_pos(input logic [POS-1:0] v);
    logic [POS_W-1:0] r;
    r = '0;
    for (int i = POS-1; i >= 0; i--)
      if (v[i]) r = POS_W'(i);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] rr_way(input logic [1:0] rr, input logic [2:0] ways);
    return WAY_W'(int'(rr) % int'(ways));
  endfunction
endpackage

// File: rtl/wpc_cfg_decode.sv
`timescale 1ns/1ps
module wpc_cfg_decode
  import wpc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic [SUB_W-1:0] sa,
  output logic [SUB_W-1:0] sel_sub,
  output logic [POS-1:0]   l1_mask,
  output logic [POS-1:0]   l2_region,
  output logic [LAT_W-1:0] lat_half,
  output logic [2:0]       ways
);
  always_comb begin
    sel_sub   = cfg[2] ? sa : {1'b0, sa[0]};
    l1_mask   = l1_mask_of(cfg, sel_sub);
    l2_region = l2_region_of(cfg);
    lat_half  = cfg_lat(cfg);
    ways      = cfg_ways(cfg);
  end
endmodule

// File: rtl/wpc_tag_store.sv
`timescale 1ns/1ps
module wpc_tag_store
  import wpc_pkg::*;
#(
  parameter int KEY_W = 5,
  parameter int IDX_W = 2,
  localparam int SETS = 1 << IDX_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [KEY_W-1:0]          cmp_key,
  input  logic                      wa_en,
  input  logic [POS_W-1:0]          wa_pos,
  input  logic [KEY_W-1:0]          wa_key,
  input  logic                      wa_vld,
  input  logic                      wb_en,
  input  logic [POS_W-1:0]          wb_pos,
  input  logic [KEY_W-1:0]          wb_key,
  input  logic                      wb_vld,
  output logic [POS-1:0]            match_vec,
  output logic [POS-1:0]            vld_vec,
  output logic [POS-1:0][KEY_W-1:0] key_vec
);
  logic [POS-1:0][KEY_W-1:0] key_q [SETS];
  logic [POS-1:0]            vld_q [SETS];

  assign vld_vec = vld_q[rd_idx];
  assign key_vec = key_q[rd_idx];

  for (genvar p = 0; p < POS; p++) begin : g_cmp
    assign match_vec[p] = vld_vec[p] && (key_vec[p] == cmp_key);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (wa_en) vld_q[rd_idx][wa_pos] <= wa_vld;
      if (wb_en) vld_q[rd_idx][wb_pos] <= wb_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wa_en) key_q[rd_idx][wa_pos] <= wa_key;
    if (wb_en) key_q[rd_idx][wb_pos] <= wb_key;
  end

  // R6/R7: the two write ports never target one position
  assert_write_ports_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_pos != wb_pos));
endmodule

// File: rtl/waypart_cache_ctrl.sv
`timescale 1ns/1ps
module waypart_cache_ctrl
  import wpc_pkg::*;
#(
  parameter int TAG_W = 3,
  parameter int IDX_W = 2,
  localparam int ADDR_W = TAG_W + 2 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [15:0]       probe_mask,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [3:0]        resp_lat_half,
  output logic              swap_valid,
  output logic [3:0]        swap_l1_pos,
  output logic [3:0]        swap_l2_pos,
  output logic              fill_valid,
  output logic [3:0]        fill_l1_pos,
  output logic              evict_valid,
  output logic [3:0]        evict_l2_pos
);
  localparam int KEY_W = TAG_W + SUB_W;

  phase_t            state;
  logic [CFG_W-1:0]  cfg_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SUB_W-1:0]  sa_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        rr_q;

  logic [SUB_W-1:0]  sel_sub;
  logic [POS-1:0]    l1_mask, l2_region;
  logic [LAT_W-1:0]  lat_half;
  logic [2:0]        ways;
  logic [KEY_W-1:0]  key;

  logic [POS-1:0]            match_vec, vld_vec;
  logic [POS-1:0][KEY_W-1:0] key_vec;

  wpc_cfg_decode u_dec (
    .cfg(cfg_q), .sa(sa_q), .sel_sub(sel_sub), .l1_mask(l1_mask),
    .l2_region(l2_region), .lat_half(lat_half), .ways(ways)
  );

  // lookup events, named for the assertions
  logic              l1_hit, rest_hit, spill;
  logic [POS-1:0]    rest_hits, inv_l1, inv_reg;
  logic [POS_W-1:0]  rest_pos, victim, dest;
  logic              vic_vld;
  logic [KEY_W-1:0]  vic_key;
  logic              finish;
  logic              wb_en, wb_vld;
  logic [POS_W-1:0]  wb_pos;

  assign key       = {tag_q, sa_q};
  assign l1_hit    = |(match_vec & l1_mask);
  assign rest_hits = match_vec & ~l1_mask;
  assign rest_hit  = |rest_hits;
  assign rest_pos  = lowest_pos(rest_hits);
  assign inv_l1    = l1_mask & ~vld_vec;
  assign victim    = (|inv_l1) ? lowest_pos(inv_l1) : {sel_sub, rr_way(rr_q, ways)};
  assign vic_vld   = vld_vec[victim];
  assign vic_key   = key_vec[victim];
  assign inv_reg   = l2_region & ~vld_vec;
  assign dest      = (|inv_reg) ? lowest_pos(inv_reg) : lowest_pos(l2_region);
  assign spill     = vic_vld && (|l2_region);
  assign finish    = (state == ST_PROBE_REST);
  assign wb_en     = finish && (rest_hit || spill);
  assign wb_pos    = rest_hit ? rest_pos : dest;
  assign wb_vld    = rest_hit ? vic_vld : 1'b1;

  wpc_tag_store #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx_q), .cmp_key(key),
    .wa_en(finish), .wa_pos(victim), .wa_key(key), .wa_vld(1'b1),
    .wb_en(wb_en), .wb_pos(wb_pos), .wb_key(vic_key), .wb_vld(wb_vld),
    .match_vec(match_vec), .vld_vec(vld_vec), .key_vec(key_vec)
  );

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_PROBE_L1:   probe_mask = l1_mask;
      ST_PROBE_REST: probe_mask = ~l1_mask;
      default:       probe_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cfg_q         <= '0;
      tag_q         <= '0;
      sa_q          <= '0;
      idx_q         <= '0;
      rr_q          <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_lat_half <= '0;
      swap_valid    <= 1'b0;
      swap_l1_pos   <= '0;
      swap_l2_pos   <= '0;
      fill_valid    <= 1'b0;
      fill_l1_pos   <= '0;
      evict_valid   <= 1'b0;
      evict_l2_pos  <= '0;
    end else begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      swap_valid  <= 1'b0;
      fill_valid  <= 1'b0;
      evict_valid <= 1'b0;
      if (cfg_we && state == ST_IDLE) cfg_q <= cfg_in;
      case (state)
        ST_IDLE: if (req_valid) begin
          idx_q <= req_addr[IDX_W-1:0];
          sa_q  <= req_addr[IDX_W +: SUB_W];
          tag_q <= req_addr[ADDR_W-1 -: TAG_W];
          state <= ST_PROBE_L1;
        end
        ST_PROBE_L1: if (l1_hit) begin
          resp_valid    <= 1'b1;
          resp_hit      <= 1'b1;
          resp_lat_half <= lat_half;
          state         <= ST_IDLE;
        end else begin
          state <= ST_PROBE_REST;
        end
        ST_PROBE_REST: begin
          resp_valid    <= 1'b1;
          resp_lat_half <= lat_half;
          rr_q          <= rr_q + 2'd1;
          if (rest_hit) begin
            swap_valid  <= 1'b1;
            swap_l1_pos <= victim;
            swap_l2_pos <= rest_pos;
          end else begin
            fill_valid   <= 1'b1;
            fill_l1_pos  <= victim;
            evict_valid  <= spill;
            evict_l2_pos <= dest;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_hit_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !(swap_valid || fill_valid || evict_valid));
  assert_miss_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $countones({swap_valid, fill_valid}) == 1);
  assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_lat_half >= 4'd4 && resp_lat_half <= 4'd9));
  assert_probe_one_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBE_L1) |-> $countones({|probe_mask[15:12], |probe_mask[11:8],
                                          |probe_mask[7:4], |probe_mask[3:0]}) == 1);
  assert_cfg_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cfg_q));
  assert_spill_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && evict_valid) |-> (fill_l1_pos != evict_l2_pos));
  assert_unique_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> $countones(match_vec) <= 1);
endmodule

// File: tb/sim_waypart_cache_ctrl.sv
`timescale 1ns/1ps
module sim_waypart_cache_ctrl;
  localparam int TW = 3;
  localparam int IW = 2;
  localparam int AW = TW + 2 + IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_in = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] probe_mask;
  logic resp_valid, resp_hit, swap_valid, fill_valid, evict_valid;
  logic [3:0] resp_lat_half, swap_l1_pos, swap_l2_pos, fill_l1_pos, evict_l2_pos;

  always #2.5 clk = ~clk;

  waypart_cache_ctrl #(.TAG_W(TW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .probe_mask(probe_mask), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_lat_half(resp_lat_half), .swap_valid(swap_valid),
    .swap_l1_pos(swap_l1_pos), .swap_l2_pos(swap_l2_pos),
    .fill_valid(fill_valid), .fill_l1_pos(fill_l1_pos),
    .evict_valid(evict_valid), .evict_l2_pos(evict_l2_pos)
  );

  int total = 0;
  int bad = 0;
  int mkey [4][16];
  bit mval [4][16];
  int mrr = 0;
  int last_swap_l2 = -1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int b_lat(input int c);
    int n = c % 4;
    if (c >= 4) return 6 + n;
    if (n == 0) return 4;
    if (n == 3) return 6;
    return 5;
  endfunction

  function automatic int b_sub(input int c, input int sa);
    return (c >= 4) ? sa : (sa % 2);
  endfunction

  function automatic logic [15:0] b_l1(input int c, input int sa);
    logic [15:0] m = '0;
    for (int w = 0; w <= c % 4; w++) m[b_sub(c, sa)*4 + w] = 1'b1;
    return m;
  endfunction

  function automatic logic [15:0] b_reg(input int c);
    logic [15:0] m = '0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        if ((c < 4 && s >= 2) || w > c % 4) m[s*4 + w] = 1'b1;
    return m;
  endfunction

  task automatic set_cfg(input int c);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_in = 3'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input int c, input int tag, input int sa, input int idx, input bit poke);
    int key = tag * 4 + sa;
    logic [15:0] l1 = b_l1(c, sa);
    logic [15:0] rg = b_reg(c);
    bit hit1 = 0;
    int hitr = -1;
    int vic = -1;
    int dest = -1;
    bit spill;
    for (int p = 0; p < 16; p++) begin
      if (mval[idx][p] && mkey[idx][p] == key) begin
        if (l1[p]) hit1 = 1;
        else if (hitr < 0) hitr = p;
      end
      if (l1[p] && !mval[idx][p] && vic < 0) vic = p;
      if (rg[p] && !mval[idx][p] && dest < 0) dest = p;
    end
    if (vic < 0) vic = b_sub(c, sa) * 4 + (mrr % (c % 4 + 1));
    if (dest < 0)
      for (int p = 15; p >= 0; p--) if (rg[p]) dest = p;

    @(negedge clk);
    req_addr = AW'((tag << (2 + IW)) | (sa << IW) | idx);
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(probe_mask == l1, "R3 first probe mask", int'(probe_mask), int'(l1));
    chk(req_ready == 1'b0, "R11 busy not ready", int'(req_ready), 0);
    if (poke) begin
      cfg_we = 1'b1;
      cfg_in = 3'((c + 3) % 8);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    if (hit1) begin
      chk(resp_valid && resp_hit, "R5 hit response", int'({resp_valid, resp_hit}), 3);
      chk(int'(resp_lat_half) == b_lat(c), "R2 R9 latency", int'(resp_lat_half), b_lat(c));
      chk(!swap_valid && !fill_valid && !evict_valid, "R5 no move on hit",
          int'({swap_valid, fill_valid, evict_valid}), 0);
    end else begin
      chk(!resp_valid, "R4 no early response", int'(resp_valid), 0);
      chk(probe_mask == ~l1, "R4 second probe mask", int'(probe_mask), int'(~l1));
      @(negedge clk);
      chk(resp_valid && !resp_hit, "R6 R7 miss response", int'({resp_valid, resp_hit}), 2);
      chk(int'(resp_lat_half) == b_lat(c), "R2 R9 latency", int'(resp_lat_half), b_lat(c));
      if (hitr >= 0) begin
        chk(swap_valid && !fill_valid, "R6 R10 swap issued", int'({swap_valid, fill_valid}), 2);
        chk(int'(swap_l1_pos) == vic, "R8 swap victim", int'(swap_l1_pos), vic);
        chk(int'(swap_l2_pos) == hitr, "R6 swap partner", int'(swap_l2_pos), hitr);
        last_swap_l2 = int'(swap_l2_pos);
        begin
          int tk = mkey[idx][vic];
          bit tv = mval[idx][vic];
          mkey[idx][vic] = key; mval[idx][vic] = 1;
          mkey[idx][hitr] = tk; mval[idx][hitr] = tv;
        end
      end else begin
        spill = mval[idx][vic] && (rg != 0);
        chk(fill_valid && !swap_valid, "R7 fill issued", int'({fill_valid, swap_valid}), 2);
        chk(int'(fill_l1_pos) == vic, "R8 fill victim", int'(fill_l1_pos), vic);
        chk(evict_valid == spill, "R7 spill flag", int'(evict_valid), int'(spill));
        if (spill) begin
          chk(int'(evict_l2_pos) == dest, "R7 spill target", int'(evict_l2_pos), dest);
          mkey[idx][dest] = mkey[idx][vic]; mval[idx][dest] = 1;
        end
        mkey[idx][vic] = key; mval[idx][vic] = 1;
      end
      mrr = (mrr + 1) % 4;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 16; p++) begin mkey[s][p] = 0; mval[s][p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
    chk(probe_mask == 16'h0, "R1 mask idle", int'(probe_mask), 0);
    acc(0, 5, 1, 2, 0);  // R1: default config 0 gives latency 4

    for (int c = 0; c < 8; c++) begin
      set_cfg(c);
      for (int rep = 0; rep < 2; rep++)
        for (int i = 0; i < 12; i++)
          acc(c, i % 6, (i / 3) % 4, i % 2, 0);
    end

    // R9: write during a busy cycle is ignored
    set_cfg(2);
    acc(2, 1, 0, 0, 1);
    acc(2, 2, 3, 1, 0);

    // R10: line placed in subarray 2 under a wide config, requested narrow
    set_cfg(4);
    acc(4, 7, 2, 3, 0);
    set_cfg(0);
    last_swap_l2 = -1;
    acc(0, 7, 2, 3, 0);
    chk(last_swap_l2 == 8, "R10 cross-config swap source", last_swap_l2, 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule